// File: doc/BRIEF.md
# USB Device Interrupt Flag Controller

This block gathers single-cycle event strobes from a USB device core and keeps each one as a sticky flag in a small register file. Software reads the flags through a simple register port. It clears a flag by writing 0 to that bit and 1 to every other bit, because writing 1 never changes a flag. A matching enable register belongs to each flag register. The block raises one interrupt request line whenever a flag and its enable are both set.

The endpoint register holds three groups of flags. The first group is one "IN token found an empty FIFO" flag per endpoint. The second group is one "packet sent and acknowledged" flag per endpoint. The last is a single cable-change flag, raised on either edge of the asynchronous VBUS detect input after that input has passed through a synchronizer. The bus register holds the wake and suspend-detect flags. These two flags only record events while the suspend-mode control input is high. The bus register also holds a configuration-valid bit. This bit is a live copy of a status level, not a sticky event.

Top module: `usb_evt_irq`

## Requirements
- R1: After reset, the endpoint flag register (address 0) reads 0. The bus flag register (address 1) reads 0x20, because only configuration-valid is set. Both enable registers (addresses 2 and 3) read 0, and irq_o is 0.
- R2: A pulse on ep_nodata_i[i] sets bit i of the endpoint flag register at the next clock edge.
- R3: A pulse on ep_txack_i[i] sets bit N_EP+i of the endpoint flag register at the next clock edge.
- R4: Either edge of vbus_det_i sets bit 2*N_EP of the endpoint flag register. The flag is visible after the third clock edge that follows the change, because of the two-stage synchronizer plus edge detection.
- R5: A pulse on bus_wake_i sets bit 3 of the bus flag register only when susp_mode_i is 1 in the same cycle. Otherwise the pulse has no effect.
- R6: A pulse on bus_susp_i sets bit 2 of the bus flag register only when susp_mode_i is 1 in the same cycle. Otherwise the pulse has no effect.
- R7: A write to a flag register clears each flag whose write-data bit is 0. Flags whose write-data bit is 1 keep their value.
- R8: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: Bit 5 of the bus flag register equals cfg_valid_i as sampled at the previous clock edge. Writes to the register do not change it.
- R10: Bits with no function read as 0 in every register, and writes to them have no effect. The endpoint registers implement bits 0 to 2*N_EP. The bus registers implement bits 5, 3 and 2.
- R11: irq_o is 1 exactly when some flag bit and the enable bit at the same position in the matching enable register are both 1. This includes configuration-valid.
- R12: A write to an enable register stores the write data for its implemented bits, and reading the register returns those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| susp_mode_i | input | 1 | Suspend-mode control; gates the wake and suspend events |
| cfg_valid_i | input | 1 | Configuration-valid status level |
| ep_nodata_i | input | N_EP | Per-endpoint pulse: IN token arrived while the FIFO held no data |
| ep_txack_i | input | N_EP | Per-endpoint pulse: packet sent and acknowledged by the host |
| vbus_det_i | input | 1 | Asynchronous VBUS detect level |
| bus_wake_i | input | 1 | Pulse: resume or bus reset seen |
| bus_susp_i | input | 1 | Pulse: bus suspend seen |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 endpoint flags, 1 bus flags, 2 endpoint enables, 3 bus enables |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data for the selected register (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the per-flag rules on every clock edge:
- an event sets its flag;
- a written 0 clears a flag unless an event arrives in the same cycle;
- a flag holds when nothing touches it;
- the wake and suspend flags cannot set while suspend mode is low;
- configuration-valid tracks its input;
- a synchronized VBUS edge raises the cable-change flag;
- with both enable registers at zero, no interrupt can be raised.

Only the bench's scenarios can show that the whole register map reads back correctly. They also cover the exact three-cycle latency of VBUS edges, the masking of unimplemented bits on writes, and irq_o under mixed enable and flag patterns. The bench reaches these through targeted sequences and a random traffic phase, compared against its reference model.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

   typedef enum logic [1:0] {
      SEL_FLAG_EP  = 2'd0,
      SEL_FLAG_BUS = 2'd1,
      SEL_EN_EP    = 2'd2,
      SEL_EN_BUS   = 2'd3
   } reg_sel_e;

   localparam int BUS_CFG_BIT  = 5;
   localparam int BUS_WAKE_BIT = 3;
   localparam int BUS_SUSP_BIT = 2;

   function automatic logic [63:0] low_ones(input int n);
      logic [63:0] m;
      m = '0;
      for (int k = 0; k < 64; k++) begin
         if (k < n) m[k] = 1'b1;
      end
      return m;
   endfunction

   function automatic logic [63:0] one_hot(input int n);
      logic [63:0] m;
      m = '0;
      m[n] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/usbirq_sync.sv
module usbirq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("usbirq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/usbirq_sticky.sv
module usbirq_sticky #(
   parameter int             W    = 8,
   parameter logic [W-1:0]   IMPL = '1,
   parameter logic [W-1:0]   RSTV = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] set_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] flag_o
);

   generate
      if (W < 1 || W > 64) begin : g_bad_width
         $error("usbirq_sticky: W out of range");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (IMPL[i]) begin : g_flop
            logic bit_q;
            logic clr;
            assign clr = wr_i && !wdata_i[i];

            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni)       bit_q <= RSTV[i];
               else if (set_i[i]) bit_q <= 1'b1;
               else if (clr)      bit_q <= 1'b0;
            end
            assign flag_o[i] = bit_q;

            // R8: an event always leaves the flag set, even against a clearing write
            p_set_sticks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
               set_i[i] |=> flag_o[i]);
            // R7: a written 0 without an event clears the flag
            p_zero_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
               (!set_i[i] && wr_i && !wdata_i[i]) |=> !flag_o[i]);
            // R7: with no event and no clearing write the flag holds
            p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
               (!set_i[i] && !(wr_i && !wdata_i[i])) |=> $stable(flag_o[i]));
         end else begin : g_tie
            assign flag_o[i] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/usb_evt_irq.sv
module usb_evt_irq
   import usbirq_pkg::*;
#(
   parameter int N_EP        = 3,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            susp_mode_i,
   input  logic            cfg_valid_i,
   input  logic [N_EP-1:0] ep_nodata_i,
   input  logic [N_EP-1:0] ep_txack_i,
   input  logic            vbus_det_i,
   input  logic            bus_wake_i,
   input  logic            bus_susp_i,
   input  logic            reg_we_i,
   input  logic [1:0]      reg_addr_i,
   input  logic [DW-1:0]   reg_wdata_i,
   output logic [DW-1:0]   reg_rdata_o,
   output logic            irq_o
);

   localparam int           EP_FLAGS   = 2 * N_EP + 1;
   localparam int           VB_BIT     = 2 * N_EP;
   localparam logic [DW-1:0] EP_MASK   = DW'(low_ones(EP_FLAGS));
   localparam logic [DW-1:0] STICKY_BUS = DW'(one_hot(BUS_WAKE_BIT) | one_hot(BUS_SUSP_BIT));
   localparam logic [DW-1:0] BUS_MASK  = STICKY_BUS | DW'(one_hot(BUS_CFG_BIT));

   generate
      if (N_EP < 1) begin : g_bad_ep
         $error("usb_evt_irq: N_EP must be at least 1");
      end
      if (EP_FLAGS > DW) begin : g_bad_ep_width
         $error("usb_evt_irq: DW too small for the endpoint flags");
      end
      if (DW <= BUS_CFG_BIT || DW > 64) begin : g_bad_dw
         $error("usb_evt_irq: DW out of range for the bus register");
      end
   endgenerate

   // ---------------- VBUS synchronizer and edge detection ----------------
   logic vb_sync;
   logic vb_last_q;
   logic vb_chg;

   usbirq_sync #(.STAGES(SYNC_STAGES)) u_vb_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (vbus_det_i),
      .sync_o  (vb_sync)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vb_last_q <= 1'b0;
      else         vb_last_q <= vb_sync;
   end
   assign vb_chg = vb_sync ^ vb_last_q;

   // ---------------- Register decode ----------------
   logic wr_flag_ep, wr_flag_bus, wr_en_ep, wr_en_bus;
   assign wr_flag_ep  = reg_we_i && (reg_addr_i == SEL_FLAG_EP);
   assign wr_flag_bus = reg_we_i && (reg_addr_i == SEL_FLAG_BUS);
   assign wr_en_ep    = reg_we_i && (reg_addr_i == SEL_EN_EP);
   assign wr_en_bus   = reg_we_i && (reg_addr_i == SEL_EN_BUS);

   // ---------------- Event vectors ----------------
   logic [DW-1:0] set_ep, set_bus;
   always_comb begin
      set_ep = '0;
      for (int e = 0; e < N_EP; e++) begin
         set_ep[e]        = ep_nodata_i[e];
         set_ep[N_EP + e] = ep_txack_i[e];
      end
      set_ep[VB_BIT] = vb_chg;
      set_bus = '0;
      set_bus[BUS_WAKE_BIT] = bus_wake_i && susp_mode_i;
      set_bus[BUS_SUSP_BIT] = bus_susp_i && susp_mode_i;
   end

   // ---------------- Flag banks ----------------
   logic [DW-1:0] flag_ep, flag_bus_st;

   usbirq_sticky #(.W(DW), .IMPL(EP_MASK), .RSTV('0)) u_ep_flags (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_ep),
      .wr_i    (wr_flag_ep),
      .wdata_i (reg_wdata_i),
      .flag_o  (flag_ep)
   );

   usbirq_sticky #(.W(DW), .IMPL(STICKY_BUS), .RSTV('0)) u_bus_flags (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_bus),
      .wr_i    (wr_flag_bus),
      .wdata_i (reg_wdata_i),
      .flag_o  (flag_bus_st)
   );

   // Configuration-valid: live status level, reset value 1
   logic cfg_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q <= 1'b1;
      else         cfg_q <= cfg_valid_i;
   end

   logic [DW-1:0] flag_bus;
   always_comb begin
      flag_bus = flag_bus_st;
      flag_bus[BUS_CFG_BIT] = cfg_q;
   end

   // ---------------- Enable registers ----------------
   logic [DW-1:0] en_ep_q, en_bus_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_ep_q  <= '0;
         en_bus_q <= '0;
      end else begin
         if (wr_en_ep)  en_ep_q  <= reg_wdata_i & EP_MASK;
         if (wr_en_bus) en_bus_q <= reg_wdata_i & BUS_MASK;
      end
   end

   // ---------------- Read mux and interrupt ----------------
   always_comb begin
      unique case (reg_addr_i)
         SEL_FLAG_EP:  reg_rdata_o = flag_ep;
         SEL_FLAG_BUS: reg_rdata_o = flag_bus;
         SEL_EN_EP:    reg_rdata_o = en_ep_q;
         default:      reg_rdata_o = en_bus_q;
      endcase
   end

   assign irq_o = (|(flag_ep & en_ep_q)) | (|(flag_bus & en_bus_q));

   // ---------------- Assertions ----------------
   // R5: without suspend mode a clear wake flag stays clear
   p_wake_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_bus[BUS_WAKE_BIT] && !susp_mode_i) |=> !flag_bus[BUS_WAKE_BIT]);
   // R6: without suspend mode a clear suspend flag stays clear
   p_susp_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_bus[BUS_SUSP_BIT] && !susp_mode_i) |=> !flag_bus[BUS_SUSP_BIT]);
   // R9: configuration-valid follows its input one edge later
   p_cfg_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_valid_i |=> flag_bus[BUS_CFG_BIT]);
   p_cfg_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_valid_i |=> !flag_bus[BUS_CFG_BIT]);
   // R4: a synchronized VBUS edge raises the cable-change flag
   p_vbus_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vb_sync != vb_last_q) |=> flag_ep[VB_BIT]);
   // R11: no enables, no interrupt
   p_irq_masked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_ep_q == '0 && en_bus_q == '0) |-> !irq_o);

endmodule

// File: tb/usb_evt_irq_test.sv
module usb_evt_irq_test;

   localparam int N  = 3;
   localparam int DW = 8;
   localparam int EP_MASK  = 8'h7F;
   localparam int BUS_MASK = 8'h2C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          susp_mode = 1'b0;
   logic          cfg_valid = 1'b1;
   logic [N-1:0]  nodata = '0;
   logic [N-1:0]  txack = '0;
   logic          vbus = 1'b0;
   logic          wake = 1'b0;
   logic          susp = 1'b0;
   logic          we = 1'b0;
   logic [1:0]    addr = 2'd0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;

   always #2 clk = ~clk;

   usb_evt_irq #(.N_EP(N), .DW(DW), .SYNC_STAGES(2)) uut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .susp_mode_i (susp_mode),
      .cfg_valid_i (cfg_valid),
      .ep_nodata_i (nodata),
      .ep_txack_i  (txack),
      .vbus_det_i  (vbus),
      .bus_wake_i  (wake),
      .bus_susp_i  (susp),
      .reg_we_i    (we),
      .reg_addr_i  (addr),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .irq_o       (irq)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // ---------------- Reference model ----------------
   int m_f0, m_f1, m_e0, m_e1;
   bit vh[$];

   function automatic int m_read(input int a);
      case (a)
         0: return m_f0;
         1: return m_f1;
         2: return m_e0;
         default: return m_e1;
      endcase
   endfunction

   function automatic int m_irq();
      return (((m_f0 & m_e0) | (m_f1 & m_e1)) != 0) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      int set0, set1, nf0, nf1;
      if (!rst_n) begin
         m_f0 = 0; m_f1 = 8'h20; m_e0 = 0; m_e1 = 0;
         vh = '{0, 0, 0, 0};
      end else begin
         set0 = int'(nodata) | (int'(txack) << N) | (((vh[1] != vh[2]) ? 1 : 0) << (2 * N));
         set1 = 0;
         if (susp_mode && wake) set1 |= 8'h08;
         if (susp_mode && susp) set1 |= 8'h04;
         nf0 = m_f0;
         nf1 = m_f1 & 8'h0C;
         if (we && addr == 2'd0) nf0 = nf0 & int'(wdata);
         if (we && addr == 2'd1) nf1 = nf1 & int'(wdata);
         m_f0 = (nf0 | set0) & EP_MASK;
         m_f1 = ((nf1 | set1) & 8'h0C) | (cfg_valid ? 8'h20 : 0);
         if (we && addr == 2'd2) m_e0 = int'(wdata) & EP_MASK;
         if (we && addr == 2'd3) m_e1 = int'(wdata) & BUS_MASK;
         vh.push_front(vbus);
         void'(vh.pop_back());
      end
   end

   task automatic chk(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Per-cycle comparison, away from the active edge
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk(cur_req, int'(rdata), m_read(int'(addr)), "rdata vs model");
         chk(cur_req, int'(irq), m_irq(), "irq vs model");
      end
   end

   // ---------------- Stimulus helpers ----------------
   task automatic cyc(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic idle();
      nodata = '0; txack = '0; wake = 1'b0; susp = 1'b0; we = 1'b0;
   endtask

   task automatic wr(input int a, input int d);
      addr = 2'(a); wdata = 8'(d); we = 1'b1;
      cyc();
      we = 1'b0;
   endtask

   task automatic look(input int a);
      addr = 2'(a);
      #0;
   endtask

   // ---------------- Scenarios ----------------
   initial begin
      cyc(3);
      rst_n = 1'b1;
      // R1: reset values
      cur_req = "R1";
      look(0); #1 chk("R1", int'(rdata), 0, "endpoint flags at reset");
      look(1); #1 chk("R1", int'(rdata), 8'h20, "bus flags at reset");
      look(2); #1 chk("R1", int'(rdata), 0, "endpoint enables at reset");
      look(3); #1 chk("R1", int'(rdata), 0, "bus enables at reset");
      chk("R1", int'(irq), 0, "irq at reset");
      cyc();

      // R12 / R10: enable write, reserved bits masked
      cur_req = "R12";
      wr(2, 8'hFF); look(2); #1 chk("R12", int'(rdata), 8'h7F, "endpoint enable readback");
      wr(3, 8'hFF); look(3); #1 chk("R10", int'(rdata), 8'h2C, "bus enable reserved masked");
      wr(2, 0); wr(3, 0);

      // R2: empty-FIFO flags per endpoint
      cur_req = "R2";
      look(0);
      for (int e = 0; e < N; e++) begin
         nodata = N'(1 << e); cyc(); idle();
      end
      #1 chk("R2", int'(rdata), 8'h07, "empty-FIFO flags");

      // R3: transmit-acknowledged flags
      cur_req = "R3";
      txack = 3'b101; cyc(); idle();
      #1 chk("R3", int'(rdata), 8'h2F, "tx-ack flags");

      // R7: write 0 clears only that bit; all ones changes nothing
      cur_req = "R7";
      wr(0, 8'hFE); look(0); #1 chk("R7", int'(rdata), 8'h2E, "clear bit 0");
      wr(0, 8'hFF); look(0); #1 chk("R7", int'(rdata), 8'h2E, "write ones keeps flags");
      wr(0, 8'h00); look(0); #1 chk("R7", int'(rdata), 0, "clear all");

      // R10: writing ones to the flag register cannot set reserved bit 7
      cur_req = "R10";
      wr(0, 8'h80); look(0); #1 chk("R10", int'(rdata), 0, "reserved flag bit");

      // R4: VBUS both edges, three-edge latency
      cur_req = "R4";
      look(0);
      vbus = 1'b1; cyc(2);
      #1 chk("R4", int'(rdata[6]), 0, "vbus flag not yet set");
      cyc();
      #1 chk("R4", int'(rdata[6]), 1, "vbus flag on rising edge");
      wr(0, 8'hBF); look(0);
      vbus = 1'b0; cyc(3);
      #1 chk("R4", int'(rdata[6]), 1, "vbus flag on falling edge");
      wr(0, 0);

      // R5 / R6: wake and suspend gated by suspend mode
      cur_req = "R5";
      look(1);
      susp_mode = 1'b0; wake = 1'b1; susp = 1'b1; cyc(); idle();
      #1 chk("R5", int'(rdata[3]), 0, "wake ignored without suspend mode");
      chk("R6", int'(rdata[2]), 0, "suspend ignored without suspend mode");
      susp_mode = 1'b1; wake = 1'b1; cyc(); idle();
      #1 chk("R5", int'(rdata[3]), 1, "wake in suspend mode");
      cur_req = "R6";
      susp = 1'b1; cyc(); idle();
      #1 chk("R6", int'(rdata[2]), 1, "suspend in suspend mode");
      susp_mode = 1'b0;

      // R8: set wins over a clearing write
      cur_req = "R8";
      addr = 2'd1; wdata = 8'h00; we = 1'b1; susp_mode = 1'b1; wake = 1'b1;
      cyc(); idle(); susp_mode = 1'b0; look(1);
      #1 chk("R8", int'(rdata & 8'h0C), 8'h08, "wake kept, suspend cleared");
      addr = 2'd0; wdata = 8'h00; we = 1'b1; txack = 3'b010;
      cyc(); idle(); look(0);
      #1 chk("R8", int'(rdata), 8'h10, "tx-ack kept over clear");
      wr(0, 0); wr(1, 0);

      // R9: configuration-valid follows input, unaffected by writes
      cur_req = "R9";
      look(1);
      cfg_valid = 1'b0; cyc();
      #1 chk("R9", int'(rdata[5]), 0, "cfg low");
      cfg_valid = 1'b1; wr(1, 8'h00); look(1);
      #1 chk("R9", int'(rdata[5]), 1, "cfg not cleared by write");

      // R11: interrupt from flag and enable pairs
      cur_req = "R11";
      chk("R11", int'(irq), 0, "no enables, no irq");
      wr(3, 8'h20);
      #1 chk("R11", int'(irq), 1, "cfg enabled raises irq");
      wr(3, 0); wr(2, 8'h04);
      #1 chk("R11", int'(irq), 0, "enable without flag");
      nodata = 3'b100; cyc(); idle();
      #1 chk("R11", int'(irq), 1, "flag and enable");
      wr(0, 8'hFB);
      #1 chk("R11", int'(irq), 0, "flag cleared drops irq");

      // Random traffic against the model
      cur_req = "R11 random";
      for (int k = 0; k < 400; k++) begin
         nodata    = N'($urandom_range(0, 7) & $urandom_range(0, 7));
         txack     = N'($urandom_range(0, 7) & $urandom_range(0, 7));
         wake      = ($urandom_range(0, 5) == 0);
         susp      = ($urandom_range(0, 5) == 0);
         susp_mode = ($urandom_range(0, 1) == 0);
         cfg_valid = ($urandom_range(0, 7) != 0);
         if ($urandom_range(0, 9) == 0) vbus = ~vbus;
         addr      = 2'($urandom_range(0, 3));
         we        = ($urandom_range(0, 3) == 0);
         wdata     = 8'($urandom_range(0, 255));
         cyc();
      end
      idle();
      cyc(4);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // Watchdog
   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule